// File: doc/BRIEF.md
# Serial-In Parallel-Out Shift Register with Strobed Output Latch

The block takes serial data on a clock and moves it through a chain of shift stages. On every rising clock edge the input bit enters the first stage and each stage takes the value of the stage before it. A latch follows the stages and drives the parallel outputs. While the strobe is high the latch is transparent. When the strobe falls, the latch holds the stage values, and shifting goes on underneath without changing the outputs.

Two serial outputs allow several blocks to be chained. The first follows the last stage and updates on the rising edge. It feeds the data input of the next block. The second copies the first on the falling clock edge that comes after, so it lags by half a clock period. This lets the next block sample it without a hold-time race.

The parallel side is offered in two forms. One is the latched data with an enable vector, for use inside a synthesized netlist. The other is a tri-state port that floats when output enable is low. Output enable has no effect on the serial outputs.

Top module: `sipo_strobe_latch`

## Requirements
- R1: On each rising edge of `clk_i`, stage 1 (bit 0) takes `data_i` and stage N (bit N-1) takes stage N-1. This is visible on `par_o` while the strobe is high.
- R2: `ser_o` carries the last stage (bit WIDTH-1) and changes only on the rising clock edge. In a chain it drives the `data_i` of the next block, so two 8-stage blocks together hold the 16 most recent bits.
- R3: `ser_dly_o` takes the value of `ser_o` on each falling clock edge. Between a rising edge and the next falling edge it still shows the value `ser_o` had before that rising edge.
- R4: While `strobe_i` is high, `par_o` follows the shift stages.
- R5: While `strobe_i` is low, `par_o` keeps the stage values present when the strobe fell, even though the stages keep shifting.
- R6: `par_oe_o` is all ones while `oe_i` is high and all zeros while it is low. While `oe_i` is high, `par_z_o` equals `par_o`; while it is low, `par_z_o` is high impedance.
- R7: `ser_o` and `ser_dly_o` keep updating whatever level `oe_i` has.
- R8: While `rst_ni` is low, the stages, the latch and `ser_dly_o` are zero, whatever the clock, data and strobe do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Latch strobe: high is transparent, low holds |
| oe_i | input | 1 | Parallel output enable |
| ser_o | output | 1 | Last stage, for chaining |
| ser_dly_o | output | 1 | Last stage delayed to the falling edge |
| par_o | output | WIDTH | Latched parallel data |
| par_oe_o | output | WIDTH | Per-bit output enable |
| par_z_o | output | WIDTH | Tri-state parallel output |

## Verification
The hardest case to reach is the hold while shifting continues. The strobe must drop, the stages must then change under a frozen latch, and the strobe must rise again so the outputs jump to stage values several shifts newer. On top of this, output enable must toggle independently.

The stimulus runs two chained blocks under a 16-bit reference model. Strobe and enable each follow their own schedule of fixed and pseudo-random phases, so that held and transparent cycles mix with enabled and floating ones. Every rising edge is followed by a check of both serial outputs and both latches, and every falling edge by a check of the half-cycle lag.

// File: rtl/slr_pkg.sv
package slr_pkg;
  parameter int unsigned SLR_DEF_WIDTH = 8;
  typedef enum logic {LAT_HOLD = 1'b0, LAT_PASS = 1'b1} lat_mode_e;
endpackage

// File: rtl/slr_shift_chain.sv
module slr_shift_chain #(
  parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  output logic [WIDTH-1:0] stage_o,
  output logic             last_o
);
  localparam int unsigned LastIdx = WIDTH - 1;

  logic [WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[LastIdx-1:0], data_i};
  end

  assign stage_o = stage_q;
  assign last_o  = stage_q[LastIdx];

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stage_q[0] == $past(data_i)); // R1
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stage_q[LastIdx:1] == $past(stage_q[LastIdx-1:0])); // R1
endmodule

// File: rtl/slr_ser_delay.sv
module slr_ser_delay (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_i,
  output logic ser_dly_o
);
  // falling-edge retime gives the next device a half-cycle hold margin
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_dly_o <= 1'b0;
    else         ser_dly_o <= ser_i;
  end

  AST_SER_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_dly_o == ser_i); // R3
endmodule

// File: rtl/slr_out_latch.sv
module slr_out_latch #(
  parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  import slr_pkg::*;

  lat_mode_e mode;
  assign mode = strobe_i ? LAT_PASS : LAT_HOLD;

  always_latch begin
    if (!rst_ni)               q_o = '0;
    else if (mode == LAT_PASS) q_o = d_i;
  end
endmodule

// File: rtl/slr_oe_drive.sv
module slr_oe_drive #(
  parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
  input  logic             oe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] oe_vec_o,
  output logic [WIDTH-1:0] z_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign oe_vec_o[i] = oe_i;
    assign z_o[i]      = oe_i ? d_i[i] : 1'bz;
  end
endmodule

// File: rtl/sipo_strobe_latch.sv
module sipo_strobe_latch #(
  parameter int unsigned WIDTH = slr_pkg::SLR_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             strobe_i,
  input  logic             oe_i,
  output logic             ser_o,
  output logic             ser_dly_o,
  output logic [WIDTH-1:0] par_o,
  output logic [WIDTH-1:0] par_oe_o,
  output logic [WIDTH-1:0] par_z_o
);
  logic [WIDTH-1:0] stage;

  slr_shift_chain #(.WIDTH(WIDTH)) i_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .stage_o(stage),
    .last_o (ser_o)
  );

  slr_ser_delay i_dly (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ser_i    (ser_o),
    .ser_dly_o(ser_dly_o)
  );

  slr_out_latch #(.WIDTH(WIDTH)) i_lat (
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .d_i     (stage),
    .q_o     (par_o)
  );

  slr_oe_drive #(.WIDTH(WIDTH)) i_drv (
    .oe_i    (oe_i),
    .d_i     (par_o),
    .oe_vec_o(par_oe_o),
    .z_o     (par_z_o)
  );

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> par_o == stage); // R4
  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && $past(!strobe_i)) |-> $stable(par_o)); // R5
  AST_SER_IS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ser_o == $past(stage[WIDTH-2])); // R2
endmodule

// File: tb/test_sipo_strobe_latch.sv
module test_sipo_strobe_latch;
  localparam int unsigned W = 8;

  typedef struct packed {
    logic         ser_a;
    logic         ser_b;
    logic [W-1:0] lat_a;
    logic [W-1:0] lat_b;
    logic         oe;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic din = 1'b0, strobe = 1'b0, oe = 1'b0;
  logic ser_a, ser_b, dly_a, dly_b;
  logic [W-1:0] par_a, par_b, oev_a, oev_b, z_a, z_b;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  logic [2*W-1:0] model = '0;
  logic [W-1:0] lat_a_m = '0, lat_b_m = '0;
  bit done = 0;

  always #5 clk = ~clk;

  sipo_strobe_latch #(.WIDTH(W)) i_sipo_strobe_latch (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(din), .strobe_i(strobe), .oe_i(oe),
    .ser_o(ser_a), .ser_dly_o(dly_a), .par_o(par_a), .par_oe_o(oev_a), .par_z_o(z_a));

  sipo_strobe_latch #(.WIDTH(W)) i_sipo_strobe_latch_hi (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(ser_a), .strobe_i(strobe), .oe_i(oe),
    .ser_o(ser_b), .ser_dly_o(dly_b), .par_o(par_b), .par_oe_o(oev_b), .par_z_o(z_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // driver: applies one bit and pushes the state expected after the next rising edge
  task automatic step(input logic d, input logic s, input logic o);
    exp_t e;
    @(posedge clk); #2;
    din = d; strobe = s; oe = o;
    model = {model[2*W-2:0], d};
    if (s) begin
      lat_a_m = model[W-1:0];
      lat_b_m = model[2*W-1:W];
    end
    e.ser_a = model[W-1];
    e.ser_b = model[2*W-1];
    e.lat_a = lat_a_m;
    e.lat_b = lat_b_m;
    e.oe    = o;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t cur;
    bit have = 0;
    forever begin
      @(posedge clk); #1;
      if (have) begin
        chk("R3 lag before fall", {31'b0, dly_a}, {31'b0, cur.ser_a});
        chk("R3 lag before fall hi", {31'b0, dly_b}, {31'b0, cur.ser_b});
      end
      if (q.size() > 0) begin
        cur = q.pop_front();
        have = 1;
        chk("R2/R7 ser_o", {31'b0, ser_a}, {31'b0, cur.ser_a});
        chk("R2 chained ser_o", {31'b0, ser_b}, {31'b0, cur.ser_b});
        chk("R1/R4/R5 par lo", {24'b0, par_a}, {24'b0, cur.lat_a});
        chk("R1/R4/R5 par hi", {24'b0, par_b}, {24'b0, cur.lat_b});
        chk("R6 oe vector", {24'b0, oev_a}, {24'b0, {W{cur.oe}}});
        if (cur.oe) chk("R6 tri-state drive", {24'b0, z_a}, {24'b0, cur.lat_a});
        @(negedge clk); #1;
        chk("R3 lag after fall", {31'b0, dly_a}, {31'b0, cur.ser_a});
        chk("R3 lag after fall hi", {31'b0, dly_b}, {31'b0, cur.ser_b});
      end
    end
  end

  initial begin
    int unsigned wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk); wd++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] word;
    // R8: reset dominates clock, data and strobe
    din = 1'b1; strobe = 1'b1; oe = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk("R8 reset par", {24'b0, par_a}, 32'd0);
    chk("R8 reset ser", {31'b0, ser_a}, 32'd0);
    @(negedge clk); #1;
    chk("R8 reset ser_dly", {30'b0, dly_a, dly_b}, 32'd0);
    chk("R8 reset par hi", {24'b0, par_b}, 32'd0);
    @(posedge clk); #2; rst_ni = 1'b1; din = 1'b0;

    // R1/R2/R4: transparent, 16-bit word through the chain
    word = 16'hA5C3;
    for (int i = 15; i >= 0; i--) step(word[i], 1'b1, 1'b1);
    // R5: hold while shifting; R7 serial keeps going with oe low
    for (int i = 0; i < 8; i++) step(i[0], 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);             // strobe returns: jump to new stages
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, i[1]);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1);
    // mixed phases
    for (int i = 0; i < 120; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      step(r[0], r[1] | r[2], r[2]);
    end
    step(1'b0, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule